// File: doc/BRIEF.md
# Interlocked Toggle-Handshake Serial Master

This block is the initiating end of a four-wire serial link that has no bit clock. One data wire and one handshake wire run in each direction. The master moves a parallel word out one bit at a time. For each bit it first sets its outgoing data wire, then flips the level of its outgoing handshake wire. It then waits until the far end flips the return handshake wire. At that point it takes the bit on the return data wire as the far end's answer. The far end therefore sets the pace of every bit, and there is no timeout.

On the user side, a word is handed over through a valid/ready pair together with a length. A one-cycle done pulse returns the collected word. A select output stays high for the whole transfer. Both return wires pass through a two-stage synchronizer before use. The outgoing handshake level is never reset between transfers, so each transfer continues flipping from wherever the previous one left it.

Top module: `hs_serial_master`

## Requirements
- R1: While reset is held and right after it, sel_o, hs_o, dout_o and done_o are 0 and req_ready is 1.
- R2: req_ready is 1 only when no transfer is in progress. A request is taken when req_valid and req_ready are both high at a clock edge, and sel_o is 1 from the next edge until the transfer ends. A req_valid raised during a transfer is ignored: it does not change the transfer and starts no new one.
- R3: The effective length L is req_len when req_len is between 1 and MAX_W, and MAX_W otherwise. The bits are sent most significant first, req_word[L-1] down to req_word[0], one bit per outgoing handshake flip.
- R4: Each new bit is on dout_o SETUP_CYC clock edges before the edge that flips hs_o. dout_o never changes on the same edge as a flip of hs_o.
- R5: hs_o flips exactly once per bit. While the synchronized return handshake level differs from hs_o (acknowledge pending), both hs_o and dout_o hold, however long that lasts.
- R6: The return wires pass through two flops. The done pulse for the final bit appears on the third rising edge after hs_i flips.
- R7: The return data wire is sampled when the acknowledge is seen. rsp_word holds the L returned bits, with the first-returned bit at position L-1, the last at position 0, and zeros above.
- R8: done_o is a one-cycle pulse raised after the final acknowledge. sel_o falls on the same edge, and rsp_word is valid while done_o is high.
- R9: hs_o keeps its level after a transfer. After a transfer of length L, hs_o equals its level before the transfer XOR the lowest bit of L.
- R10: No waiting time aborts a transfer. A far end that delays every bit by tens of cycles still gets a complete, correct transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | A word is offered for transfer |
| req_ready | output | 1 | Master is idle and will take a word |
| req_word | input | MAX_W | Word to send, right-aligned |
| req_len | input | $clog2(MAX_W+1) | Bits to send; 0 or above MAX_W means MAX_W |
| done_o | output | 1 | One-cycle pulse at transfer end |
| rsp_word | output | MAX_W | Word returned by the far end, right-aligned |
| sel_o | output | 1 | Frame select, high for the whole transfer |
| dout_o | output | 1 | Outgoing data wire |
| hs_o | output | 1 | Outgoing handshake wire (bit marked by a level flip) |
| din_i | input | 1 | Return data wire |
| hs_i | input | 1 | Return handshake wire |

## Verification
A modelled far end drives the return wires on falling edges. It changes din_i one cycle before flipping hs_i, so both reach the core through the same synchronizer stages. The timing of each result is fixed:
- sel_o is checked one falling edge after the request edge.
- Each new bit must already be on dout_o one falling edge before hs_o flips.
- The done pulse must appear three rising edges after the final hs_i flip. A free-running rising-edge counter measures this, so the check does not depend on the order of processes at an edge.
- Expected returned words go into a queue when a transfer is issued. A falling-edge monitor pops one entry on each done pulse and compares it. The far-end model compares the captured outgoing bits after sel_o falls.

// File: rtl/hsm_pkg.sv
package hsm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_WAIT  = 2'd2
    } state_e;
endpackage

// File: rtl/hsm_sync.sv
module hsm_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[0] <= '0;
                else        stage_q[0] <= async_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/hsm_core.sv
module hsm_core #(
    parameter int MAX_W     = 16,
    parameter int SETUP_CYC = 1,
    parameter int LW        = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [MAX_W-1:0] req_word,
    input  logic [LW-1:0]    req_len,
    output logic             req_ready,
    input  logic             hs_sync,
    input  logic             din_sync,
    output logic             sel_o,
    output logic             dout_o,
    output logic             hs_o,
    output logic             done_o,
    output logic [MAX_W-1:0] rsp_o
);
    import hsm_pkg::*;

    localparam int CW = (SETUP_CYC > 1) ? $clog2(SETUP_CYC) : 1;

    typedef struct packed {
        state_e           st;
        logic [CW-1:0]    cnt;
        logic [LW-1:0]    left;
        logic [MAX_W-1:0] tx;
        logic [MAX_W-1:0] rx;
        logic [MAX_W-1:0] rsp;
        logic             sel;
        logic             hs;
        logic             dout;
        logic             done;
    } core_t;

    core_t r_q, r_d;
    logic [LW-1:0] len_eff;
    logic [LW-1:0] shamt;
    logic          ack;

    always_comb begin
        if (req_len == '0 || req_len > LW'(MAX_W)) len_eff = LW'(MAX_W);
        else                                       len_eff = req_len;
        shamt = LW'(MAX_W) - len_eff;
        ack   = (hs_sync == r_q.hs);

        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_SETUP;
                    r_d.sel  = 1'b1;
                    r_d.cnt  = '0;
                    r_d.left = len_eff;
                    r_d.tx   = req_word << shamt;
                    r_d.dout = r_d.tx[MAX_W-1];
                    r_d.rx   = '0;
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == CW'(SETUP_CYC - 1)) begin
                    r_d.hs = ~r_q.hs;
                    r_d.st = ST_WAIT;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            ST_WAIT: begin
                if (ack) begin
                    r_d.rx = (r_q.rx << 1) | MAX_W'(din_sync);
                    if (r_q.left == LW'(1)) begin
                        r_d.st   = ST_IDLE;
                        r_d.sel  = 1'b0;
                        r_d.done = 1'b1;
                        r_d.rsp  = r_d.rx;
                    end else begin
                        r_d.left = r_q.left - 1'b1;
                        r_d.tx   = r_q.tx << 1;
                        r_d.dout = r_d.tx[MAX_W-1];
                        r_d.cnt  = '0;
                        r_d.st   = ST_SETUP;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, cnt: '0, left: '0, tx: '0, rx: '0,
                     rsp: '0, sel: 1'b0, hs: 1'b0, dout: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign req_ready = (r_q.st == ST_IDLE);
    assign sel_o     = r_q.sel;
    assign dout_o    = r_q.dout;
    assign hs_o      = r_q.hs;
    assign done_o    = r_q.done;
    assign rsp_o     = r_q.rsp;

    // R2: ready only while no frame is open
    p_ready_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !sel_o);
    // R2: a taken request opens the frame on the next edge
    p_accept_sel_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> sel_o);
    // R4: data never moves on the edge that flips the handshake
    p_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_o != $past(hs_o)) |-> ($stable(dout_o) && sel_o));
    // R5: both outputs hold while an acknowledge is outstanding
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_o && (hs_sync != hs_o)) |=> ($stable(hs_o) && $stable(dout_o)));
    // R8: done coincides with the frame closing
    p_done_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!sel_o && $past(sel_o)));
    // R8: done lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);
endmodule

// File: rtl/hs_serial_master.sv
module hs_serial_master #(
    parameter int MAX_W     = 16,
    parameter int SETUP_CYC = 1,
    parameter int LW        = $clog2(MAX_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [MAX_W-1:0] req_word,
    input  logic [LW-1:0]    req_len,
    output logic             done_o,
    output logic [MAX_W-1:0] rsp_word,
    output logic             sel_o,
    output logic             dout_o,
    output logic             hs_o,
    input  logic             din_i,
    input  logic             hs_i
);
    logic [1:0] ret_sync;

    hsm_sync #(.W(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({hs_i, din_i}),
        .sync_o  (ret_sync)
    );

    hsm_core #(.MAX_W(MAX_W), .SETUP_CYC(SETUP_CYC), .LW(LW)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_word  (req_word),
        .req_len   (req_len),
        .req_ready (req_ready),
        .hs_sync   (ret_sync[1]),
        .din_sync  (ret_sync[0]),
        .sel_o     (sel_o),
        .dout_o    (dout_o),
        .hs_o      (hs_o),
        .done_o    (done_o),
        .rsp_o     (rsp_word)
    );
endmodule

// File: tb/hs_serial_master_tb.sv
module hs_serial_master_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_W      = 16;
    localparam int LW         = $clog2(MAX_W + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [MAX_W-1:0] req_word = '0;
    logic [LW-1:0]    req_len = '0;
    logic             done_o;
    logic [MAX_W-1:0] rsp_word;
    logic             sel_o, dout_o, hs_o;
    logic             din_i = 1'b0;
    logic             hs_i = 1'b0;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int last_cyc = 0;
    bit finished = 0;

    logic [MAX_W-1:0] exp_q [$];
    logic [MAX_W-1:0] slv_tx = '0, slv_resp = '0, slv_got = '0;
    int slv_len = 1;
    int slv_dly = 0;

    hs_serial_master #(.MAX_W(MAX_W), .SETUP_CYC(1)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_word(req_word), .req_len(req_len), .done_o(done_o),
        .rsp_word(rsp_word), .sel_o(sel_o), .dout_o(dout_o), .hs_o(hs_o),
        .din_i(din_i), .hs_i(hs_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [MAX_W-1:0] lmask(input int le);
        return (le >= MAX_W) ? '1 : ((MAX_W'(1) << le) - 1'b1);
    endfunction

    // far-end model
    initial begin
        logic seen;
        logic prev_d;
        logic d0;
        bit ok;
        int idx;
        seen = 1'b0; prev_d = 1'b0; idx = 0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                seen = 1'b0;
            end else begin
                if (!sel_o) idx = 0;
                if (hs_o != seen) begin
                    seen = hs_o;
                    chk(sel_o == 1'b1, "R2 frame open at bit", sel_o, 1);
                    chk(dout_o == prev_d, "R4 data set before flip", dout_o, prev_d);
                    chk(dout_o == slv_tx[slv_len-1-idx], "R3 bit order", dout_o, slv_tx[slv_len-1-idx]);
                    if (idx == 0) slv_got = '0;
                    slv_got = {slv_got[MAX_W-2:0], dout_o};
                    d0 = dout_o;
                    ok = 1;
                    for (int k = 0; k < slv_dly; k++) begin
                        @(negedge clk);
                        if (hs_o != seen || dout_o != d0) ok = 0;
                    end
                    chk(ok, "R5 hold while ack pending", ok, 1);
                    din_i = slv_resp[slv_len-1-idx];
                    @(negedge clk);
                    hs_i = ~hs_i;
                    if (idx == slv_len - 1) last_cyc = cyc;
                    idx++;
                end
                prev_d = dout_o;
            end
        end
    end

    // scoreboard monitor
    initial begin
        logic [MAX_W-1:0] e;
        forever begin
            @(negedge clk);
            if (rst_n && done_o) begin
                if (exp_q.size() == 0) begin
                    chk(0, "R8 unexpected done", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(rsp_word == e, "R7 returned word", rsp_word, e);
                end
                chk(sel_o == 1'b0, "R8 select falls with done", sel_o, 0);
                chk(cyc == last_cyc + 3, "R6 done latency after last ack", cyc - last_cyc, 3);
            end
        end
    end

    task automatic xfer(input logic [MAX_W-1:0] w, input int len, input logic [MAX_W-1:0] resp,
                        input int dly, input bit poke);
        int le;
        logic hs_before;
        le = (len < 1 || len > MAX_W) ? MAX_W : len;
        slv_tx = w; slv_resp = resp; slv_len = le; slv_dly = dly;
        exp_q.push_back(resp & lmask(le));
        hs_before = hs_o;
        @(negedge clk);
        chk(req_ready == 1'b1, "R2 ready when idle", req_ready, 1);
        req_valid = 1'b1; req_word = w; req_len = LW'(len);
        @(negedge clk);
        req_valid = 1'b0;
        chk(sel_o == 1'b1, "R2 select after accept", sel_o, 1);
        if (poke) begin
            @(negedge clk);
            chk(req_ready == 1'b0, "R2 busy not ready", req_ready, 0);
            req_valid = 1'b1; req_word = ~w; req_len = LW'(3);
            @(negedge clk);
            req_valid = 1'b0;
        end
        do @(negedge clk); while (sel_o);
        repeat (5) @(negedge clk);
        chk(sel_o == 1'b0, "R2 no extra transfer", sel_o, 0);
        chk(exp_q.size() == 0, "R8 one done per transfer", exp_q.size(), 0);
        chk((slv_got & lmask(le)) == (w & lmask(le)), "R3 word sent", slv_got, w & lmask(le));
        chk(hs_o == (hs_before ^ le[0]), "R9 handshake level kept", hs_o, hs_before ^ le[0]);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(sel_o == 0 && hs_o == 0 && dout_o == 0 && done_o == 0, "R1 outputs in reset",
            {sel_o, hs_o, dout_o, done_o}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1 && sel_o == 1'b0, "R1 idle after reset", {req_ready, sel_o}, 2'b10);
        xfer(16'hA5C3, 16, 16'h3C5A, 0, 1);
        xfer(16'h00B7, 8, 16'h0049, 3, 0);
        xfer(16'h0001, 1, 16'h0001, 0, 0);
        xfer(16'h1234, 0, 16'hFFFF, 1, 0);
        xfer(16'h0005, 3, 16'h0002, 60, 0);   // R10 slow far end
        xfer(16'hBEEF, 20, 16'h8001, 2, 1);
        xfer(16'h0013, 5, 16'h0015, 0, 0);
        chk(1'b1, "R10 slow transfers completed", 1, 1);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            chk(0, "watchdog", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule